// File: doc/BRIEF.md
# Power control and reset-status register

An 8-bit control and status register for a small microcontroller core. It holds the control bits for serial baud doubling, the power-fail interrupt enable, the watchdog-reset enable and the low-power stop and idle requests. It also keeps two sticky status flags: one for a supply-warning condition and one for a watchdog-caused reset. A third flag, set by software, tells a power-on reset apart from any later one. Each bit reacts to a different set of reset kinds. Some bits can only be written while a timed-access window is open, and the two status flags clear when the register is read.

The CPU reads the register with a one-cycle read strobe. The read data is driven combinationally during that strobe, and any read-to-clear action takes effect at the following clock edge. Writes use a write strobe and a data byte. Each reset kind arrives on its own active-high, single-cycle pulse input: a cold power-on (no backup supply), a warm power-on (backup supply present), a watchdog timeout and an external reset pin. All state changes are synchronous to the clock.

Top module: `pwr_ctl_reg`

## Requirements
- R1: While `bus_rd` is high, `rd_data` shows the register with bit 7 baud-double, bit 6 power-on flag, bit 5 supply warning, bit 4 watchdog-reset flag, bit 3 power-fail interrupt enable, bit 2 watchdog enable, bit 1 stop and bit 0 idle. The value shown is the one held before any clear caused by that read. While `bus_rd` is low, `rd_data` is zero.
- R2: Bits 7 and 3 take the written value on any write. Any hardware reset (one of the four reset pulses) clears them.
- R3: Bits 6, 2 and 1 change on a write only when `ta_open` is high. If `ta_open` is low, those bits keep their value, and the other bits of the same write are still updated.
- R4: The power-on flag (bit 6) is cleared by either power-on reset. A watchdog reset or an external reset leaves it unchanged.
- R5: The supply warning (bit 5) is set in every cycle that `supply_low` is high. It stays set until a read and is cleared by a read. It stays 1 across that read if `supply_low` is still high. Either power-on reset clears it.
- R6: The watchdog-reset flag (bit 4) is set by `rst_wdt` and cleared by a read. Either power-on reset clears it, and this wins over an `rst_wdt` in the same cycle. An external reset leaves it unchanged.
- R7: The watchdog enable (bit 2), output on `wdt_en`, is cleared only by `rst_cold_por`. All other reset kinds keep it.
- R8: The stop bit (bit 1), output on `stop_mode`, is cleared by any hardware reset.
- R9: The idle bit (bit 0), output on `idle_mode`, is cleared by `irq_taken` or by any hardware reset. `irq_taken` wins over a write of 1 in the same cycle.
- R10: `pf_irq` is high exactly when both the supply warning and the power-fail interrupt enable are set. `baud_x2` follows bit 7.
- R11: If a flag's set condition and a clearing read fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| bus_rd | input | 1 | One-cycle register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | DATA_W | Write data |
| ta_open | input | 1 | Timed-access window open |
| rst_cold_por | input | 1 | Power-on reset pulse, no backup supply |
| rst_warm_por | input | 1 | Power-on reset pulse, backup supply present |
| rst_wdt | input | 1 | Watchdog timeout reset pulse |
| rst_ext | input | 1 | External reset pulse |
| supply_low | input | 1 | Synchronized supply-below-warning comparator |
| irq_taken | input | 1 | Interrupt accepted pulse |
| rd_data | output | DATA_W | Read data, zero when not reading |
| pf_irq | output | 1 | Power-fail interrupt request |
| baud_x2 | output | 1 | Serial baud doubling |
| wdt_en | output | 1 | Watchdog reset enable |
| stop_mode | output | 1 | Stop mode request |
| idle_mode | output | 1 | Idle mode request |

## Verification
Two pairs of functions can collide in one cycle: a flag's set event with the read that clears it, and a power-on reset with a watchdog reset. The bench provokes both. It reads while `supply_low` is held and while `rst_wdt` pulses, and it drives a cold power-on together with `rst_wdt`. It judges each result by the value read back in the next read cycle. A behavioural model that applies the same requirements is compared against every output on every clock, while random traffic creates further overlaps of writes, reads, interrupts and resets.

// File: rtl/pcr_pkg.sv
package pcr_pkg;
   localparam int REG_W   = 8;
   localparam int N_CTRL  = 6;

   localparam int POS_BAUD = 7;
   localparam int POS_PON  = 6;
   localparam int POS_PFW  = 5;
   localparam int POS_WTR  = 4;
   localparam int POS_EPF  = 3;
   localparam int POS_EWD  = 2;
   localparam int POS_STOP = 1;
   localparam int POS_IDLE = 0;

   typedef enum logic [1:0] {
      CLR_ANY_HW   = 2'd0,
      CLR_ANY_POR  = 2'd1,
      CLR_COLD_POR = 2'd2
   } clr_src_e;

   typedef struct packed {
      logic hw_any;
      logic por_any;
      logic cold_por;
      logic wdt_only;
   } rst_view_t;
endpackage

// File: rtl/pcr_reset_decode.sv
module pcr_reset_decode
   import pcr_pkg::*;
(
   input  logic      cold_por,
   input  logic      warm_por,
   input  logic      wdt,
   input  logic      ext,
   output rst_view_t rv
);
   always_comb begin
      rv.cold_por = cold_por;
      rv.por_any  = cold_por | warm_por;
      rv.hw_any   = cold_por | warm_por | wdt | ext;
      rv.wdt_only = wdt & ~(cold_por | warm_por);
   end
endmodule

// File: rtl/pcr_sticky_flag.sv
module pcr_sticky_flag (
   input  logic clk,
   input  logic clr_por,
   input  logic set_evt,
   input  logic rd_clr,
   output logic q
);
   always_ff @(posedge clk) begin
      if (clr_por)      q <= 1'b0;
      else if (set_evt) q <= 1'b1;
      else if (rd_clr)  q <= 1'b0;
   end

   // R11
   set_wins_chk: assert property (@(posedge clk) disable iff (clr_por)
      set_evt |=> q);

   // R5
   rd_clear_chk: assert property (@(posedge clk) disable iff (clr_por)
      (rd_clr && !set_evt) |=> !q);
endmodule

// File: rtl/pcr_ctrl_bit.sv
module pcr_ctrl_bit
   import pcr_pkg::*;
#(
   parameter bit       TIMED   = 1'b0,
   parameter clr_src_e CLR_SRC = CLR_ANY_HW
) (
   input  logic      clk,
   input  rst_view_t rv,
   input  logic      wr_en,
   input  logic      ta_open,
   input  logic      wr_bit,
   input  logic      ext_clr,
   output logic      q
);
   logic rst_hit;
   logic wr_ok;

   generate
      if (CLR_SRC == CLR_ANY_HW) begin : g_hw
         assign rst_hit = rv.hw_any;
      end else if (CLR_SRC == CLR_ANY_POR) begin : g_por
         assign rst_hit = rv.por_any;
      end else begin : g_cold
         assign rst_hit = rv.cold_por;
      end

      if (TIMED) begin : g_timed
         assign wr_ok = wr_en & ta_open;
      end else begin : g_free
         assign wr_ok = wr_en;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst_hit || ext_clr) q <= 1'b0;
      else if (wr_ok)         q <= wr_bit;
   end

   // R2
   wr_taken_chk: assert property (@(posedge clk) disable iff (rst_hit)
      (wr_en && (ta_open || !TIMED) && !ext_clr) |=> (q == $past(wr_bit)));

   // R9
   ext_clr_chk: assert property (@(posedge clk) disable iff (rst_hit)
      ext_clr |=> !q);

   generate
      if (TIMED) begin : g_ta_chk
         // R3
         ta_blocked_chk: assert property (@(posedge clk) disable iff (rst_hit)
            (wr_en && !ta_open && !ext_clr) |=> $stable(q));
      end
   endgenerate
endmodule

// File: rtl/pwr_ctl_reg.sv
module pwr_ctl_reg
   import pcr_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              ta_open,
   input  logic              rst_cold_por,
   input  logic              rst_warm_por,
   input  logic              rst_wdt,
   input  logic              rst_ext,
   input  logic              supply_low,
   input  logic              irq_taken,
   output logic [DATA_W-1:0] rd_data,
   output logic              pf_irq,
   output logic              baud_x2,
   output logic              wdt_en,
   output logic              stop_mode,
   output logic              idle_mode
);
   localparam int PAD_W = DATA_W - REG_W;

   localparam int       CTRL_POS   [N_CTRL] = '{POS_BAUD, POS_PON, POS_EPF,
                                               POS_EWD, POS_STOP, POS_IDLE};
   localparam bit       CTRL_TIMED [N_CTRL] = '{1'b0, 1'b1, 1'b0,
                                               1'b1, 1'b1, 1'b0};
   localparam clr_src_e CTRL_CLR   [N_CTRL] = '{CLR_ANY_HW, CLR_ANY_POR,
                                               CLR_ANY_HW, CLR_COLD_POR,
                                               CLR_ANY_HW, CLR_ANY_HW};

   initial begin
      assert (DATA_W >= REG_W)
         else $fatal(1, "pwr_ctl_reg: DATA_W must be at least %0d", REG_W);
   end

   rst_view_t        rv;
   logic [REG_W-1:0] reg_q;

   pcr_reset_decode u_rst (
      .cold_por (rst_cold_por),
      .warm_por (rst_warm_por),
      .wdt      (rst_wdt),
      .ext      (rst_ext),
      .rv       (rv)
   );

   generate
      for (genvar i = 0; i < N_CTRL; i++) begin : g_ctl
         logic ext_clr;
         if (CTRL_POS[i] == POS_IDLE) begin : g_irq
            assign ext_clr = irq_taken;
         end else begin : g_none
            assign ext_clr = 1'b0;
         end

         pcr_ctrl_bit #(
            .TIMED   (CTRL_TIMED[i]),
            .CLR_SRC (CTRL_CLR[i])
         ) u_bit (
            .clk     (clk),
            .rv      (rv),
            .wr_en   (bus_wr),
            .ta_open (ta_open),
            .wr_bit  (bus_wdata[CTRL_POS[i]]),
            .ext_clr (ext_clr),
            .q       (reg_q[CTRL_POS[i]])
         );
      end
   endgenerate

   pcr_sticky_flag u_pfw (
      .clk     (clk),
      .clr_por (rv.por_any),
      .set_evt (supply_low),
      .rd_clr  (bus_rd),
      .q       (reg_q[POS_PFW])
   );

   pcr_sticky_flag u_wtr (
      .clk     (clk),
      .clr_por (rv.por_any),
      .set_evt (rv.wdt_only),
      .rd_clr  (bus_rd),
      .q       (reg_q[POS_WTR])
   );

   generate
      if (PAD_W > 0) begin : g_pad
         assign rd_data = bus_rd ? {{PAD_W{1'b0}}, reg_q} : '0;
      end else begin : g_nopad
         assign rd_data = bus_rd ? reg_q : '0;
      end
   endgenerate

   assign pf_irq    = reg_q[POS_PFW] & reg_q[POS_EPF];
   assign baud_x2   = reg_q[POS_BAUD];
   assign wdt_en    = reg_q[POS_EWD];
   assign stop_mode = reg_q[POS_STOP];
   assign idle_mode = reg_q[POS_IDLE];

   // R6
   por_beats_wdt_chk: assert property (@(posedge clk) disable iff (rst_wdt && !rv.por_any)
      rv.por_any |=> !reg_q[POS_WTR]);

   // R7
   ewd_kept_chk: assert property (@(posedge clk) disable iff (rst_cold_por)
      (!bus_wr && (rst_warm_por || rst_wdt || rst_ext)) |=> $stable(wdt_en));
endmodule

// File: tb/test_pwr_ctl_reg.sv
`timescale 1ns/1ps
module test_pwr_ctl_reg;
   logic       clk = 1'b0;
   logic       bus_rd = 0, bus_wr = 0, ta_open = 0;
   logic [7:0] bus_wdata = 8'h00;
   logic       rst_cold_por = 0, rst_warm_por = 0, rst_wdt = 0, rst_ext = 0;
   logic       supply_low = 0, irq_taken = 0;
   logic [7:0] rd_data;
   logic       pf_irq, baud_x2, wdt_en, stop_mode, idle_mode;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   bit armed  = 0;
   logic [7:0] last_rd;

   // behavioural reference state
   bit m_baud, m_pon, m_pfw, m_wtr, m_epf, m_ewd, m_stop, m_idle;

   always #2.5 clk = ~clk;

   pwr_ctl_reg #(.DATA_W(8)) i_pwr_ctl_reg (
      .clk(clk), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
      .ta_open(ta_open), .rst_cold_por(rst_cold_por), .rst_warm_por(rst_warm_por),
      .rst_wdt(rst_wdt), .rst_ext(rst_ext), .supply_low(supply_low),
      .irq_taken(irq_taken), .rd_data(rd_data), .pf_irq(pf_irq),
      .baud_x2(baud_x2), .wdt_en(wdt_en), .stop_mode(stop_mode),
      .idle_mode(idle_mode)
   );

   function automatic logic [7:0] model_word();
      return {m_baud, m_pon, m_pfw, m_wtr, m_epf, m_ewd, m_stop, m_idle};
   endfunction

   task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %02h expected %02h at %0t", tag, got, exp, $time);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         checks++; fails++;
         $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
         summary();
      end
   end

   // one bus cycle; entered and left at a falling edge
   task automatic cyc(input bit rd, input bit wr, input logic [7:0] wd, input bit ta,
                      input bit cold, input bit warm, input bit wdt, input bit ext,
                      input bit low, input bit irq);
      bit hw, por;
      if (armed) begin
         chk("R10 pf_irq",    {7'd0, pf_irq},    {7'd0, m_pfw & m_epf});
         chk("R10 baud_x2",   {7'd0, baud_x2},   {7'd0, m_baud});
         chk("R7 wdt_en",     {7'd0, wdt_en},    {7'd0, m_ewd});
         chk("R8 stop_mode",  {7'd0, stop_mode}, {7'd0, m_stop});
         chk("R9 idle_mode",  {7'd0, idle_mode}, {7'd0, m_idle});
      end
      bus_rd = rd; bus_wr = wr; bus_wdata = wd; ta_open = ta;
      rst_cold_por = cold; rst_warm_por = warm; rst_wdt = wdt; rst_ext = ext;
      supply_low = low; irq_taken = irq;
      #1;
      last_rd = rd_data;
      if (armed) chk("R1 rd_data", rd_data, rd ? model_word() : 8'h00);
      @(posedge clk);
      hw  = cold | warm | wdt | ext;
      por = cold | warm;
      // control bits
      if (hw) begin m_baud = 0; m_epf = 0; m_stop = 0; end
      else if (wr) begin
         m_baud = wd[7]; m_epf = wd[3];
         if (ta) m_stop = wd[1];
      end
      if (hw || irq) m_idle = 0; else if (wr) m_idle = wd[0];
      if (por) m_pon = 0; else if (wr && ta) m_pon = wd[6];
      if (cold) m_ewd = 0; else if (wr && ta) m_ewd = wd[2];
      // flags
      if (por) m_pfw = 0; else if (low) m_pfw = 1; else if (rd) m_pfw = 0;
      if (por) m_wtr = 0; else if (wdt) m_wtr = 1; else if (rd) m_wtr = 0;
      armed = 1;
      @(negedge clk);
   endtask

   task automatic idle_cyc();
      cyc(0, 0, 8'h00, 0, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic rd_cyc();
      cyc(1, 0, 8'h00, 0, 0, 0, 0, 0, 0, 0);
   endtask

   initial begin
      @(negedge clk);
      // R8 cold power-on brings everything to zero
      cyc(0, 0, 8'h00, 0, 1, 0, 0, 0, 0, 0);
      rd_cyc(); chk("R8 reset word", last_rd, 8'h00);

      // R3 write all ones without timed access: only free bits change
      cyc(0, 1, 8'hFF, 0, 0, 0, 0, 0, 0, 0);
      rd_cyc(); chk("R3 free-only write", last_rd, 8'h89);

      // R9 interrupt beats a write of idle in the same cycle
      cyc(0, 1, 8'h89, 0, 0, 0, 0, 0, 0, 1);
      rd_cyc(); chk("R9 irq wins", last_rd, 8'h88);

      // R3 timed write sets the protected bits
      cyc(0, 1, 8'hFF, 1, 0, 0, 0, 0, 0, 0);
      rd_cyc(); chk("R3 timed write", last_rd, 8'hCF);

      // R4 R7 external reset keeps power-on flag and watchdog enable
      cyc(0, 0, 8'h00, 0, 0, 0, 0, 1, 0, 0);
      rd_cyc(); chk("R4 ext keeps", last_rd, 8'h44);

      // R5 warning latches after a one-cycle pulse, read clears it
      cyc(0, 1, 8'h08, 0, 0, 0, 0, 0, 1, 0);
      idle_cyc();
      rd_cyc(); chk("R5 latched", last_rd, 8'h6C);
      rd_cyc(); chk("R5 cleared", last_rd, 8'h4C);

      // R11 read while supply still low keeps the warning
      cyc(1, 0, 8'h00, 0, 0, 0, 0, 0, 1, 0);
      cyc(1, 0, 8'h00, 0, 0, 0, 0, 0, 0, 0); chk("R11 pfw reasserts", last_rd, 8'h6C);

      // R6 watchdog flag: set, survives external reset, read clears
      cyc(0, 0, 8'h00, 0, 0, 0, 1, 0, 0, 0);
      cyc(0, 0, 8'h00, 0, 0, 0, 0, 1, 0, 0);
      rd_cyc(); chk("R6 wtr kept", last_rd, 8'h54);
      rd_cyc(); chk("R6 wtr cleared", last_rd, 8'h44);

      // R11 watchdog reset together with a read
      cyc(1, 0, 8'h00, 0, 0, 0, 1, 0, 0, 0);
      rd_cyc(); chk("R11 wtr set wins", last_rd, 8'h54);

      // R4 R7 warm power-on clears power-on flag and wtr, keeps enable
      cyc(0, 0, 8'h00, 0, 0, 1, 0, 0, 0, 0);
      rd_cyc(); chk("R4 warm por", last_rd, 8'h04);

      // R6 R7 cold power-on with watchdog reset in the same cycle
      cyc(0, 1, 8'h40, 1, 0, 0, 0, 0, 0, 0);
      cyc(0, 0, 8'h00, 0, 1, 0, 1, 0, 0, 0);
      rd_cyc(); chk("R6 por beats wdt", last_rd, 8'h00);

      // R2 R10 interrupt request only with both bits
      cyc(0, 1, 8'h88, 0, 0, 0, 0, 0, 1, 0);
      idle_cyc(); chk("R10 pf_irq on", {7'd0, pf_irq}, 8'h01);
      cyc(0, 1, 8'h00, 0, 0, 0, 0, 0, 0, 0);
      idle_cyc(); chk("R2 epf cleared", {7'd0, pf_irq}, 8'h00);

      // random traffic against the model
      for (int n = 0; n < 4000; n++) begin
         int r = $urandom_range(0, 99);
         cyc($urandom_range(0, 9) < 3, $urandom_range(0, 9) < 3, 8'($urandom),
             $urandom_range(0, 1) == 1,
             r == 0, r == 1, r == 2 || r == 3, r == 4,
             $urandom_range(0, 9) == 0, $urandom_range(0, 9) == 0);
      end
      summary();
   end
endmodule